// File: doc/BRIEF.md
# Slot-Valid Receive Stream Buffer

This block takes one inbound sample stream of a serial audio/modem link controller. The frame deserializer ahead of it presents a per-frame latch strobe, the slot-valid tag bit for this stream and the slot's 20-bit sample. When the strobe arrives with the tag set and the stream enabled, the sample is written into a small FIFO. A request/acknowledge handshake then lets a DMA engine drain the FIFO to memory one sample per acknowledge.

Two independent enables control the block. The stream enable gates capture, and clearing it empties the FIFO. The DMA enable gates the drain request. A valid sample that arrives with no free space is discarded, and it raises a sticky overrun flag that software clears with a one-cycle clear pulse.

Top module: `rx_slot_stream`

## Requirements
- R1: A sample is written to the FIFO only in a cycle where `frame_strobe`, `slot_valid` and `stream_en` are all high. A strobe without the tag, or a tag without the strobe, writes nothing.
- R2: While `stream_en` is low, valid slots are ignored and the FIFO is emptied on the next clock edge. Samples captured before the stream was disabled never reach `dma_data`.
- R3: The FIFO holds DEPTH (default 8) samples of SAMPLE_W (default 20) bits in arrival order. `dma_data` always shows the oldest stored sample.
- R4: `dma_req` goes high in the cycle after the edge that brings the fill level to DEPTH/2 (default 4) or more, provided `dma_en` is high. Below that level a new request does not start.
- R5: Once raised, `dma_req` stays high until the FIFO is empty. It drops after the first edge at which `dma_en` is sampled low.
- R6: A high `dma_ack` while `dma_req` is high removes the oldest sample at that edge. A `dma_ack` while `dma_req` is low changes nothing.
- R7: A capture attempt against a full FIFO with no removal in the same cycle is an overrun. The new sample is discarded, the stored samples are unchanged, and `overrun` is set.
- R8: `overrun` is sticky. It clears only on an edge where `overrun_clr` is high and no new overrun occurs, because a new overrun wins over the clear.
- R9: After synchronous active-low reset, the FIFO is empty and both `dma_req` and `overrun` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_strobe | input | 1 | One-cycle latch strobe per received frame |
| slot_valid | input | 1 | Slot-valid tag for this stream in the current frame |
| slot_data | input | SAMPLE_W | Sample carried in this stream's slot |
| stream_en | input | 1 | Capture enable; low flushes the FIFO |
| dma_en | input | 1 | Drain request enable |
| dma_ack | input | 1 | DMA acknowledge, removes the oldest sample |
| dma_req | output | 1 | DMA drain request |
| dma_data | output | SAMPLE_W | Oldest stored sample |
| overrun | output | 1 | Sticky overrun error flag |
| overrun_clr | input | 1 | Write-one-to-clear pulse for `overrun` |

## Verification
The bench fills the FIFO to exactly half depth to catch an off-by-one request threshold. A design with that fault would request one sample early or late. It drains the FIFO to empty to show the request is held through the level band below the threshold, where a plain level comparison would drop it too soon. It pushes a ninth sample into a full FIFO and then drains it. This exposes a design that overwrites the head or tail, or that loses the sticky flag.

The bench also acknowledges while no request is pending, where a careless pop would silently consume data. It disables the stream with samples stored and checks that none of them reappear after re-enabling, which a design without the flush would get wrong.

// File: rtl/rxs_pkg.sv
// Package: shared defaults for the receive stream buffer.
// Assumes: samples are right-aligned in SAMPLE_W bits.
package rxs_pkg;
    localparam int DEF_SAMPLE_W = 20;
    localparam int DEF_DEPTH    = 8;
endpackage

// File: rtl/rxs_fifo.sv
// Module: rxs_fifo
// Circular sample store with a synchronous flush and a show-ahead read port.
// Assumes: the caller never pushes when full unless it also pops, and never
// pops when empty. DEPTH is a power of two.
module rxs_fifo #(
    parameter int WIDTH = rxs_pkg::DEF_SAMPLE_W,
    parameter int DEPTH = rxs_pkg::DEF_DEPTH,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] rd_data,
    output logic [LVL_W-1:0] level,
    output logic [LVL_W-1:0] level_next
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    // Purpose: compute the fill level that the next edge will produce.
    always_comb begin
        if (flush)
            level_next = '0;
        else
            level_next = level + LVL_W'(push) - LVL_W'(pop);
    end

    // Purpose: advance the pointers and the level, or clear them on reset or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + PTR_W'(1);
            if (pop)  rd_ptr <= rd_ptr + PTR_W'(1);
            level <= level_next;
        end
    end

    // Purpose: write an accepted sample into storage.
    always_ff @(posedge clk) begin
        if (push && !flush)
            mem[wr_ptr] <= wr_data;
    end

    assign rd_data = mem[rd_ptr];

    // The fill level never exceeds DEPTH (R3).
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));

    // A flush leaves the store empty at the next edge (R2).
    assert_flush_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (level == '0));
endmodule

// File: rtl/rxs_capture.sv
// Module: rxs_capture
// Decides whether a tagged slot is stored or lost, and holds the overrun flag.
// Assumes: full and pop describe the FIFO state in the same cycle.
module rxs_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_strobe,
    input  logic slot_valid,
    input  logic stream_en,
    input  logic full,
    input  logic pop,
    input  logic overrun_clr,
    output logic push,
    output logic overrun
);
    logic attempt, lost;

    // Purpose: qualify the capture attempt and split it into accept or lose.
    always_comb begin
        attempt = frame_strobe && slot_valid && stream_en;
        push    = attempt && (!full || pop);
        lost    = attempt && full && !pop;
    end

    // Purpose: keep the sticky overrun flag; a new loss wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            overrun <= 1'b0;
        else if (lost)
            overrun <= 1'b1;
        else if (overrun_clr)
            overrun <= 1'b0;
    end

    // No sample is stored without a qualified, tagged slot (R1).
    assert_push_qualified_R1: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (frame_strobe && slot_valid && stream_en));

    // The flag falls only through a clear pulse (R8).
    assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(overrun) |-> $past(overrun_clr));

    // A loss against a full store always raises the flag (R7).
    assert_overrun_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_strobe && slot_valid && stream_en && full && !pop) |=> overrun);
endmodule

// File: rtl/rxs_drain_req.sv
// Module: rxs_drain_req
// Generates the DMA request with hysteresis: it starts at half depth and
// holds until empty.
// Assumes: level_next is the fill level that the coming edge will load.
module rxs_drain_req #(
    parameter int DEPTH = rxs_pkg::DEF_DEPTH,
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int HALF  = DEPTH / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dma_en,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] level_next,
    output logic             dma_req
);
    // Purpose: start a request at half depth and release it at empty.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dma_req <= 1'b0;
        else if (!dma_en)
            dma_req <= 1'b0;
        else if (dma_req)
            dma_req <= (level_next != '0);
        else
            dma_req <= (level_next >= LVL_W'(HALF));
    end

    // A request drops only at empty or after the enable went low (R5).
    assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dma_req) |-> (level == '0 || !$past(dma_en)));

    // A request never starts below half depth (R4).
    assert_req_threshold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_req) |-> (level >= LVL_W'(HALF)));
endmodule

// File: rtl/rx_slot_stream.sv
// Module: rx_slot_stream (top)
// One receive stream: tagged-slot capture into a FIFO, with DMA drain and
// overrun detection.
// Assumes: frame_strobe is high for one cycle per frame, and slot_valid and
// slot_data are stable while it is high.
module rx_slot_stream #(
    parameter int SAMPLE_W = rxs_pkg::DEF_SAMPLE_W,
    parameter int DEPTH    = rxs_pkg::DEF_DEPTH,
    localparam int LVL_W   = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_strobe,
    input  logic                slot_valid,
    input  logic [SAMPLE_W-1:0] slot_data,
    input  logic                stream_en,
    input  logic                dma_en,
    input  logic                dma_ack,
    output logic                dma_req,
    output logic [SAMPLE_W-1:0] dma_data,
    output logic                overrun,
    input  logic                overrun_clr
);
    logic             push, pop, full;
    logic [LVL_W-1:0] level, level_next;

    // Purpose: derive the full flag and the acknowledged pop.
    always_comb begin
        full = (level == LVL_W'(DEPTH));
        pop  = dma_ack && dma_req && (level != '0) && stream_en;
    end

    rxs_capture u_capture (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_strobe (frame_strobe),
        .slot_valid   (slot_valid),
        .stream_en    (stream_en),
        .full         (full),
        .pop          (pop),
        .overrun_clr  (overrun_clr),
        .push         (push),
        .overrun      (overrun)
    );

    rxs_fifo #(.WIDTH(SAMPLE_W), .DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (!stream_en),
        .push       (push),
        .pop        (pop),
        .wr_data    (slot_data),
        .rd_data    (dma_data),
        .level      (level),
        .level_next (level_next)
    );

    rxs_drain_req #(.DEPTH(DEPTH)) u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .dma_en     (dma_en),
        .level      (level),
        .level_next (level_next),
        .dma_req    (dma_req)
    );

    // An acknowledge without a request leaves the level untouched (R6).
    assert_ack_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_ack && !dma_req && !push && stream_en) |=> $stable(level));
endmodule

// File: tb/test_rx_slot_stream.sv
// Directed bench for rx_slot_stream: one task per scenario, with a queue
// model of the expected FIFO contents.
module test_rx_slot_stream;
    localparam int W = 20;
    localparam int D = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         frame_strobe = 1'b0, slot_valid = 1'b0;
    logic [W-1:0] slot_data = '0;
    logic         stream_en = 1'b0, dma_en = 1'b0, dma_ack = 1'b0, overrun_clr = 1'b0;
    logic         dma_req, overrun;
    logic [W-1:0] dma_data;

    int checks = 0, failures = 0;
    bit done = 1'b0;
    logic [W-1:0] model [$];

    always #10 clk = ~clk;

    rx_slot_stream i_rx_slot_stream (
        .clk(clk), .rst_n(rst_n), .frame_strobe(frame_strobe), .slot_valid(slot_valid),
        .slot_data(slot_data), .stream_en(stream_en), .dma_en(dma_en), .dma_ack(dma_ack),
        .dma_req(dma_req), .dma_data(dma_data), .overrun(overrun), .overrun_clr(overrun_clr)
    );

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One frame: strobe with the given tag and data; the model follows R1/R7.
    task automatic frame(input bit valid, input logic [W-1:0] d);
        frame_strobe = 1'b1; slot_valid = valid; slot_data = d;
        if (valid && stream_en && model.size() < D) model.push_back(d);
        @(negedge clk);
        frame_strobe = 1'b0; slot_valid = 1'b0;
    endtask

    task automatic ack();
        dma_ack = 1'b1;
        @(negedge clk);
        dma_ack = 1'b0;
    endtask

    task automatic drain_all(input string req);
        while (model.size() > 0) begin
            check(dma_req == 1'b1, {req, " req held"}, dma_req, 1);
            check(dma_data == model[0], {req, " order"}, dma_data, model[0]);
            void'(model.pop_front());
            ack();
        end
        check(dma_req == 1'b0, {req, " req drop at empty"}, dma_req, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; model.delete();
        repeat (2) @(negedge clk);
        rst_n = 1'b1; stream_en = 1'b1; dma_en = 1'b1;
        @(negedge clk);
        check(dma_req == 0, "R9 req", dma_req, 0);
        check(overrun == 0, "R9 overrun", overrun, 0);
    endtask

    task automatic t_threshold();
        frame(1'b0, 20'hBAD00);
        dma_ack = 1'b0;
        frame_strobe = 1'b0; slot_valid = 1'b1; @(negedge clk); slot_valid = 1'b0;
        for (int i = 0; i < 3; i++) frame(1'b1, 20'h10000 + 20'(i));
        check(dma_req == 0, "R4 below half", dma_req, 0);
        check(dma_data == 20'h10000, "R1 untagged slot skipped", dma_data, 20'h10000);
        frame(1'b1, 20'h10003);
        check(dma_req == 1, "R4 at half", dma_req, 1);
        drain_all("R5");
    endtask

    task automatic t_ack_ignored();
        frame(1'b1, 20'h20000);
        frame(1'b1, 20'h20001);
        ack();
        check(dma_req == 0, "R6 no req", dma_req, 0);
        frame(1'b1, 20'h20002);
        frame(1'b1, 20'h20003);
        check(dma_data == 20'h20000, "R6 ack ignored head", dma_data, 20'h20000);
        drain_all("R6");
    endtask

    task automatic t_dma_gate();
        dma_en = 1'b0;
        for (int i = 0; i < 5; i++) frame(1'b1, 20'h30000 + 20'(i));
        check(dma_req == 0, "R5 dma_en low no req", dma_req, 0);
        dma_en = 1'b1; @(negedge clk);
        check(dma_req == 1, "R4 req after enable", dma_req, 1);
        dma_en = 1'b0; @(negedge clk);
        check(dma_req == 0, "R5 drop on disable", dma_req, 0);
        dma_en = 1'b1; @(negedge clk);
        drain_all("R3");
    endtask

    task automatic t_overrun();
        dma_en = 1'b0;
        for (int i = 0; i < D; i++) frame(1'b1, 20'h40000 + 20'(i));
        check(overrun == 0, "R7 full no overrun", overrun, 0);
        frame(1'b1, 20'h4FFFF);
        check(overrun == 1, "R7 overrun set", overrun, 1);
        check(dma_data == 20'h40000, "R7 head kept", dma_data, 20'h40000);
        dma_en = 1'b1; @(negedge clk);
        drain_all("R7");
        check(overrun == 1, "R8 sticky", overrun, 1);
        overrun_clr = 1'b1; @(negedge clk); overrun_clr = 1'b0;
        check(overrun == 0, "R8 cleared", overrun, 0);
        dma_en = 1'b0;
        for (int i = 0; i < D; i++) frame(1'b1, 20'h41000 + 20'(i));
        overrun_clr = 1'b1; frame(1'b1, 20'h41FFF); overrun_clr = 1'b0;
        check(overrun == 1, "R8 set wins over clear", overrun, 1);
        overrun_clr = 1'b1; @(negedge clk); overrun_clr = 1'b0;
        dma_en = 1'b1; @(negedge clk);
        drain_all("R3");
    endtask

    task automatic t_flush();
        dma_en = 1'b0;
        for (int i = 0; i < 3; i++) frame(1'b1, 20'h50000 + 20'(i));
        stream_en = 1'b0; model.delete();
        @(negedge clk);
        frame(1'b1, 20'h5DEAD);
        stream_en = 1'b1;
        for (int i = 0; i < 4; i++) frame(1'b1, 20'h51000 + 20'(i));
        dma_en = 1'b1; @(negedge clk);
        check(dma_data == 20'h51000, "R2 flushed head", dma_data, 20'h51000);
        drain_all("R2");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_threshold();
        t_ack_ignored();
        t_dma_gate();
        t_overrun();
        t_flush();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule